// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

This block is an eight-pin general-purpose I/O port that sits behind a 4 KB register window on a simple 32-bit single-cycle read/write bus. Software sets each pin as input or output and moves pin data through the low 1 KB of the window. In that region the word-address bits act as a per-pin mask, so a single store can change chosen pins without a read-modify-write. Reads are combinational from the current address. Writes take effect at the rising clock edge on which `bus_sel` and `bus_wr` are both high.

Every pin can raise an interrupt. A pin fires on a rising edge, a falling edge or either edge, or it tracks a level. Pending events are kept in a raw status register, and one combined interrupt line reports the events that are enabled. The block also holds the pad-setting registers: drive strength, open drain, pulls, slew, digital enable and analog select. The alternate-function select register is guarded by a key-operated lock and a commit mask. A read-only table of identification bytes fills the top of the window. Pin inputs pass through a synchronizer before any logic sees them.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, all registers read zero except two: the lock flag reads 1 and the commit mask reads 0xFF. `pin_out`, `pin_oe` and `irq` are all 0.
- R2: A write with `bus_addr[11:10]==0` changes only those output-latch bits that are set in both `bus_addr[9:2]` and the direction register (0x400, bit=1 means output). Each such bit takes the matching bit of `bus_wdata[7:0]`.
- R3: A read with `bus_addr[11:10]==0` returns `bus_addr[9:2]` ANDed with the port value. The port value is the latch bit for an output pin and the synchronized `pin_in` bit for an input pin. Bits 31:8 read zero.
- R4: The configuration registers keep only `bus_wdata[7:0]` and read back zero-extended. They are direction 0x400, level select 0x404, both-edge select 0x408, polarity 0x40C, enable mask 0x410, drive 0x500/0x504/0x508, open drain 0x50C, pull-up 0x510, pull-down 0x514, slew 0x518, digital enable 0x51C and analog select 0x528.
- R5: Writing exactly 0x0ACCE551 to 0x520 unlocks the port. Writing any other value to 0x520 locks it. A read of 0x520 returns 1 when locked and 0 when unlocked.
- R6: The commit mask at 0x524 changes only on a write made while unlocked. A write to alternate select at 0x420 changes only the bits that are set in the commit mask.
- R7: Reads of 0xFD0 to 0xFFC return byte ((addr-0xFD0)>>2) of the identification table, zero-extended. The default table is 00,00,00,00,61,10,04,00,0D,F0,05,B1.
- R8: A pin whose level-select bit is 0 is in edge mode. If its both-edge bit is 1, any change of the synchronized input sets its raw status bit (read at 0x414). Otherwise polarity 1 reacts to rising edges and polarity 0 to falling edges. The status bit then stays set.
- R9: A pin whose level-select bit is 1 has a raw status bit equal to (synchronized input == polarity bit) on every cycle.
- R10: Writing 1s to 0x41C clears those bits of raw status for pins in edge mode, and 0 bits leave status unchanged. If an edge event arrives in the same cycle as the clear, the event wins.
- R11: `irq` is the OR of raw status ANDed with the enable mask. The masked status register at 0x418 returns that AND.
- R12: Reads of undefined offsets return zero, and writes to them change no register.
- R13: `pin_out` carries the output latch and `pin_oe` carries the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Output latch to the pads |
| pin_oe | output | 8 | Per-pin output enable |
| irq | output | 1 | Combined interrupt |

## Verification
A write to the clear register and a new edge event can reach raw status on the same clock edge. The bench forces this by changing a pin exactly two cycles before a clear lands, so that the synchronized edge and the clear are registered together. The clear covers both the new pin and an older pending pin. The result is judged by reading raw status: the older bit must be gone and the new bit must remain. A data write and a direction change can also meet in one access sequence. The random phase interleaves them and compares `pin_out` and masked data reads against a bench model after each step.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int PIN_W  = 8;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] A_DIR    = 12'h400;
    localparam logic [ADDR_W-1:0] A_LVL    = 12'h404;
    localparam logic [ADDR_W-1:0] A_BOTH   = 12'h408;
    localparam logic [ADDR_W-1:0] A_POL    = 12'h40C;
    localparam logic [ADDR_W-1:0] A_IEN    = 12'h410;
    localparam logic [ADDR_W-1:0] A_RAW    = 12'h414;
    localparam logic [ADDR_W-1:0] A_MSK    = 12'h418;
    localparam logic [ADDR_W-1:0] A_CLR    = 12'h41C;
    localparam logic [ADDR_W-1:0] A_ALT    = 12'h420;
    localparam logic [ADDR_W-1:0] A_DRV2   = 12'h500;
    localparam logic [ADDR_W-1:0] A_DRV4   = 12'h504;
    localparam logic [ADDR_W-1:0] A_DRV8   = 12'h508;
    localparam logic [ADDR_W-1:0] A_ODRN   = 12'h50C;
    localparam logic [ADDR_W-1:0] A_PUP    = 12'h510;
    localparam logic [ADDR_W-1:0] A_PDN    = 12'h514;
    localparam logic [ADDR_W-1:0] A_SLEW   = 12'h518;
    localparam logic [ADDR_W-1:0] A_DEN    = 12'h51C;
    localparam logic [ADDR_W-1:0] A_LOCK   = 12'h520;
    localparam logic [ADDR_W-1:0] A_COMMIT = 12'h524;
    localparam logic [ADDR_W-1:0] A_ANA    = 12'h528;
    localparam logic [ADDR_W-1:0] A_ID_LO  = 12'hFD0;

    localparam logic [BUS_W-1:0] UNLOCK_KEY = 32'h0ACC_E551;

    typedef logic [PIN_W-1:0] pins_t;

    typedef struct packed {
        pins_t dout;
        pins_t dir;
        pins_t lvl;
        pins_t both;
        pins_t pol;
        pins_t ien;
        pins_t raw;
        pins_t alt;
        pins_t drv2;
        pins_t drv4;
        pins_t drv8;
        pins_t odrn;
        pins_t pup;
        pins_t pdn;
        pins_t slew;
        pins_t den;
        pins_t ana;
        pins_t commit;
        logic  locked;
    } regs_t;

    localparam regs_t REGS_RST = '{commit: 8'hFF, locked: 1'b1, default: '0};
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out,
    output logic [W-1:0] prev_out
);
    logic [W-1:0] chain_q [STAGES+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= '0;
        else        chain_q[0] <= async_in;
    end

    for (genvar s = 1; s <= STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
        end
    end

    assign sync_out = chain_q[STAGES-1];
    assign prev_out = chain_q[STAGES];
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] both,
    input  logic [W-1:0] pol,
    output logic [W-1:0] edge_hit,
    output logic [W-1:0] level_hit
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rise, fall;
        assign rise         = cur[i] & ~prev[i];
        assign fall         = ~cur[i] & prev[i];
        assign edge_hit[i]  = both[i] ? (rise | fall) : (pol[i] ? rise : fall);
        assign level_hit[i] = (cur[i] == pol[i]);
    end
endmodule

// File: rtl/gpio_id_rom.sv
module gpio_id_rom #(
    parameter int          N     = 12,
    parameter logic [95:0] TABLE = 96'hB105F00D_00041061_00000000
) (
    input  logic [3:0] idx,
    output logic [7:0] id_byte
);
    always_comb begin
        id_byte = '0;
        for (int k = 0; k < N; k++) begin
            if (idx == 4'(k)) id_byte = TABLE[k*8 +: 8];
        end
    end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter logic [95:0] ID_TABLE    = 96'hB105F00D_00041061_00000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe,
    output logic              irq
);
    localparam int PAD_W = BUS_W - PIN_W;

    regs_t st_q, st_d;
    pins_t pin_sync, pin_prev, edge_hit, level_hit, clr_bits, dmask, wd8, port_val;
    logic  wr_en, in_data, in_id;
    logic [7:0] id_byte;

    gpio_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in),
        .sync_out(pin_sync), .prev_out(pin_prev)
    );

    gpio_evt_detect #(.W(PIN_W)) u_evt (
        .cur(pin_sync), .prev(pin_prev), .both(st_q.both), .pol(st_q.pol),
        .edge_hit(edge_hit), .level_hit(level_hit)
    );

    gpio_id_rom #(.TABLE(ID_TABLE)) u_id (
        .idx(bus_addr[5:2] - 4'd4), .id_byte(id_byte)
    );

    assign wr_en    = bus_sel & bus_wr;
    assign in_data  = (bus_addr[11:10] == 2'b00);
    assign in_id    = (bus_addr >= A_ID_LO);
    assign dmask    = bus_addr[9:2];
    assign wd8      = bus_wdata[PIN_W-1:0];
    assign clr_bits = (wr_en && bus_addr == A_CLR) ? wd8 : '0;
    assign port_val = (st_q.dir & st_q.dout) | (~st_q.dir & pin_sync);

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (in_data) begin
                st_d.dout = (st_q.dout & ~(dmask & st_q.dir)) | (wd8 & dmask & st_q.dir);
            end else begin
                case (bus_addr)
                    A_DIR:    st_d.dir  = wd8;
                    A_LVL:    st_d.lvl  = wd8;
                    A_BOTH:   st_d.both = wd8;
                    A_POL:    st_d.pol  = wd8;
                    A_IEN:    st_d.ien  = wd8;
                    A_ALT:    st_d.alt  = (st_q.alt & ~st_q.commit) | (wd8 & st_q.commit);
                    A_DRV2:   st_d.drv2 = wd8;
                    A_DRV4:   st_d.drv4 = wd8;
                    A_DRV8:   st_d.drv8 = wd8;
                    A_ODRN:   st_d.odrn = wd8;
                    A_PUP:    st_d.pup  = wd8;
                    A_PDN:    st_d.pdn  = wd8;
                    A_SLEW:   st_d.slew = wd8;
                    A_DEN:    st_d.den  = wd8;
                    A_ANA:    st_d.ana  = wd8;
                    A_LOCK:   st_d.locked = (bus_wdata != UNLOCK_KEY);
                    A_COMMIT: if (!st_q.locked) st_d.commit = wd8;
                    default:  ;
                endcase
            end
        end
        // level pins follow the pin; edge pins are sticky, set beats clear
        st_d.raw = (st_q.lvl & level_hit)
                 | (~st_q.lvl & ((st_q.raw & ~clr_bits) | edge_hit));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= REGS_RST;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (in_data) begin
                bus_rdata = {{PAD_W{1'b0}}, port_val & dmask};
            end else if (in_id) begin
                bus_rdata = {{PAD_W{1'b0}}, id_byte};
            end else begin
                case (bus_addr)
                    A_DIR:    bus_rdata = {{PAD_W{1'b0}}, st_q.dir};
                    A_LVL:    bus_rdata = {{PAD_W{1'b0}}, st_q.lvl};
                    A_BOTH:   bus_rdata = {{PAD_W{1'b0}}, st_q.both};
                    A_POL:    bus_rdata = {{PAD_W{1'b0}}, st_q.pol};
                    A_IEN:    bus_rdata = {{PAD_W{1'b0}}, st_q.ien};
                    A_RAW:    bus_rdata = {{PAD_W{1'b0}}, st_q.raw};
                    A_MSK:    bus_rdata = {{PAD_W{1'b0}}, st_q.raw & st_q.ien};
                    A_ALT:    bus_rdata = {{PAD_W{1'b0}}, st_q.alt};
                    A_DRV2:   bus_rdata = {{PAD_W{1'b0}}, st_q.drv2};
                    A_DRV4:   bus_rdata = {{PAD_W{1'b0}}, st_q.drv4};
                    A_DRV8:   bus_rdata = {{PAD_W{1'b0}}, st_q.drv8};
                    A_ODRN:   bus_rdata = {{PAD_W{1'b0}}, st_q.odrn};
                    A_PUP:    bus_rdata = {{PAD_W{1'b0}}, st_q.pup};
                    A_PDN:    bus_rdata = {{PAD_W{1'b0}}, st_q.pdn};
                    A_SLEW:   bus_rdata = {{PAD_W{1'b0}}, st_q.slew};
                    A_DEN:    bus_rdata = {{PAD_W{1'b0}}, st_q.den};
                    A_ANA:    bus_rdata = {{PAD_W{1'b0}}, st_q.ana};
                    A_LOCK:   bus_rdata = {{(BUS_W-1){1'b0}}, st_q.locked};
                    A_COMMIT: bus_rdata = {{PAD_W{1'b0}}, st_q.commit};
                    default:  bus_rdata = '0;
                endcase
            end
        end
    end

    assign pin_out = st_q.dout;
    assign pin_oe  = st_q.dir;
    assign irq     = |(st_q.raw & st_q.ien);
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [11:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic [7:0]  pin_out,
    input logic [7:0]  pin_oe,
    input logic        locked_q,
    input logic [7:0]  commit_q,
    input logic [7:0]  alt_q
);
    logic [7:0] data_wmask;
    assign data_wmask = (bus_sel && bus_wr && bus_addr[11:10] == 2'b00)
                      ? (bus_addr[9:2] & pin_oe) : 8'h00;

    p_lock_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 12'h520 && bus_wdata == 32'h0ACCE551) |=> !locked_q);

    p_commit_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && bus_sel && bus_wr && bus_addr == 12'h524) |=> $stable(commit_q));

    p_alt_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((alt_q ^ $past(alt_q)) & ~$past(commit_q)) == 8'h00));

    p_out_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pin_out ^ $past(pin_out)) & ~$past(data_wmask)) == 8'h00));

    p_id_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr >= 12'hFD0) |-> (bus_rdata[31:8] == 24'h0));
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_out(pin_out), .pin_oe(pin_oe), .locked_q(st_q.locked),
    .commit_q(st_q.commit), .alt_q(st_q.alt)
);

// File: tb/gpio_port_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_port_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pin_in = '0, pin_out, pin_oe;
    logic        irq;

    int checks = 0, errors = 0;
    logic [7:0] m_dir = '0, m_out = '0, m_pins = '0;

    always #2 clk = ~clk;

    gpio_port_ctrl u_gpio_port_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    function automatic logic [7:0] id_ref(int k);
        logic [7:0] t [12] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h61, 8'h10,
                                8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        return t[k];
    endfunction

    function automatic logic [31:0] exp_data(logic [7:0] mask);
        return {24'h0, ((m_dir & m_out) | (~m_dir & m_pins)) & mask};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic set_pins(logic [7:0] v);
        @(negedge clk);
        pin_in = v; m_pins = v;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'h1234_5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 pin_oe", {24'h0, pin_oe}, 32'h0);
        check("R1 pin_out", {24'h0, pin_out}, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        rd(12'h520, r); check("R1 lock", r, 32'h1);
        rd(12'h524, r); check("R1 commit", r, 32'hFF);
        rd(12'h414, r); check("R1 raw", r, 32'h0);
        rd(12'h420, r); check("R1 alt", r, 32'h0);

        // R4 configuration registers keep low byte
        foreach (A_LIST[i]) begin
            logic [7:0] v = 8'($urandom);
            wr(A_LIST[i], {24'hABCDEF, v});
            rd(A_LIST[i], r); check("R4 cfg", r, {24'h0, v});
        end
        wr(12'h400, 32'h0); m_dir = 8'h00;

        // R12 undefined offsets
        wr(12'h500, 32'h3C);
        wr(12'h42C, 32'hFFFF_FFFF);
        rd(12'h42C, r); check("R12 undef read", r, 32'h0);
        rd(12'h600, r); check("R12 undef read", r, 32'h0);
        rd(12'h500, r); check("R12 no side effect", r, 32'h3C);

        // R7 identification bytes
        for (int k = 0; k < 12; k++) begin
            rd(12'(12'hFD0 + 4 * k), r); check("R7 id", r, {24'h0, id_ref(k)});
        end

        // R5/R6 lock and commit
        wr(12'h524, 32'h0F); rd(12'h524, r); check("R6 commit locked", r, 32'hFF);
        wr(12'h420, 32'hA5); rd(12'h420, r); check("R6 alt full", r, 32'hA5);
        wr(12'h520, 32'h0ACCE551); rd(12'h520, r); check("R5 unlock", r, 32'h0);
        wr(12'h524, 32'h0F); rd(12'h524, r); check("R6 commit open", r, 32'h0F);
        wr(12'h420, 32'h5A); rd(12'h420, r); check("R6 alt masked", r, 32'hAA);
        wr(12'h520, 32'h0ACCE550); rd(12'h520, r); check("R5 relock", r, 32'h1);
        wr(12'h524, 32'h00); rd(12'h524, r); check("R6 commit held", r, 32'h0F);

        // R2/R3/R13 random data path
        for (int it = 0; it < 80; it++) begin
            int op = int'($urandom % 3);
            logic [7:0] v = 8'($urandom);
            logic [7:0] mk = 8'($urandom);
            if (op == 0) begin
                wr(12'h400, {24'h0, v}); m_dir = v;
            end else if (op == 1) begin
                wr({2'b00, mk, 2'b00}, {24'h0, v});
                m_out = (m_out & ~(mk & m_dir)) | (v & mk & m_dir);
            end else begin
                set_pins(v);
            end
            check("R13 pin_out", {24'h0, pin_out}, {24'h0, m_out});
            check("R13 pin_oe", {24'h0, pin_oe}, {24'h0, m_dir});
            mk = 8'($urandom);
            rd({2'b00, mk, 2'b00}, r); check("R3 masked read", r, exp_data(mk));
        end
        // R2 directed: all output, write through mask 0x0F only
        wr(12'h400, 32'hFF); m_dir = 8'hFF;
        wr({2'b00, 8'hFF, 2'b00}, 32'h00);
        wr({2'b00, 8'h0F, 2'b00}, 32'hFF);
        check("R2 mask write", {24'h0, pin_out}, 32'h0F);
        wr(12'h400, 32'h00); m_dir = 8'h00;
        set_pins(8'h00);
        wr(12'h41C, 32'hFF);

        // R8 edge modes
        wr(12'h404, 32'h00); wr(12'h408, 32'h00);
        wr(12'h40C, 32'hFF); wr(12'h410, 32'hFF);
        set_pins(8'h05);
        rd(12'h414, r); check("R8 rising", r, 32'h05);
        check("R11 irq", {31'h0, irq}, 32'h1);
        rd(12'h418, r); check("R11 masked", r, 32'h05);
        wr(12'h41C, 32'hFF);
        rd(12'h414, r); check("R10 clear", r, 32'h0);
        check("R11 irq low", {31'h0, irq}, 32'h0);
        wr(12'h40C, 32'hFE);
        set_pins(8'h04);
        rd(12'h414, r); check("R8 falling", r, 32'h01);
        wr(12'h41C, 32'hFF);
        wr(12'h408, 32'h02);
        set_pins(8'h06);
        rd(12'h414, r); check("R8 both rise", r, 32'h02);
        wr(12'h41C, 32'hFF);
        set_pins(8'h04);
        rd(12'h414, r); check("R8 both fall", r, 32'h02);
        wr(12'h41C, 32'hFF);

        // R10 clear and new event in the same cycle
        set_pins(8'h14);
        rd(12'h414, r); check("R10 pre", r, 32'h10);
        @(negedge clk); pin_in = 8'h34; m_pins = 8'h34;
        @(negedge clk);
        wr(12'h41C, 32'h30);
        rd(12'h414, r); check("R10 set wins", r, 32'h20);
        wr(12'h41C, 32'hFF);

        // R9 level mode on pin 3 (polarity bit 3 = 1)
        wr(12'h404, 32'h08);
        repeat (2) @(negedge clk);
        rd(12'h414, r); check("R9 level low", r, 32'h0);
        set_pins(8'h3C);
        rd(12'h414, r); check("R9 level high", r, 32'h08);
        wr(12'h41C, 32'h08);
        rd(12'h414, r); check("R9 clear ignored", r, 32'h08);
        set_pins(8'h34);
        rd(12'h414, r); check("R9 follows", r, 32'h0);

        // R11 enable mask
        set_pins(8'h3C);
        wr(12'h410, 32'h00);
        check("R11 masked off", {31'h0, irq}, 32'h0);
        rd(12'h418, r); check("R11 masked reg", r, 32'h0);
        wr(12'h410, 32'h08);
        check("R11 masked on", {31'h0, irq}, 32'h1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    localparam logic [11:0] A_LIST [14] = '{12'h400, 12'h404, 12'h408, 12'h40C, 12'h410,
        12'h500, 12'h504, 12'h508, 12'h50C, 12'h510, 12'h514, 12'h518, 12'h51C, 12'h528};
endmodule